// File: doc/BRIEF.md
# Dual-Unit In-Order Commit Buffer

This block sits between a two-wide dispatch stage and the architectural register file of a small core with one integer execution unit and one floating-point execution unit. Each cycle it can take up to two decoded instructions in program order. It gives each one a slot in an eight-entry circular buffer and starts it in a latency stub that stands for the matching execution unit. The integer stub takes one cycle and the floating-point stub takes three, so results come back out of order.

A result that arrives early is parked in the data field of its own slot, which acts as a temporary register. Results leave the buffer strictly in program order. Up to two of the oldest finished slots write the register file in one cycle, and retirement stops at the first slot that has not finished. When the oldest slot finishes with an exception, it writes nothing. The block then reports that slot's tag, discards every younger slot and every result still in flight, and takes new dispatches into the freed buffer from the next cycle on.

Top module: `dual_commit_buf`

## Requirements
- R1: Dispatch lane 0 is the older lane. Lane 1 may be valid only together with lane 0, and two lanes in one cycle must target different units. An accepted lane 0 takes slot tag `dispTag[2:0]`, which is the tail pointer. An accepted lane 1 takes `dispTag[5:3]`, which is the tail plus one modulo 8. The tail then advances by the number of accepted lanes.
- R2: `dispReady` is high exactly when at least two of the eight slots are free and no exception is being reported in that cycle. Lanes offered while it is low are not taken.
- R3: If an integer instruction is accepted at clock edge e, its result may first appear on the write port in the cycle after edge e+1. For a floating-point instruction, this happens in the cycle after edge e+3.
- R4: Register-file writes appear in dispatch order. Port lane 0 (`rfWe[0]`, low field of `rfAddr`/`rfData`) always carries the older write, and lane 1 may write only when lane 0 does. At most two writes happen per cycle.
- R5: A finished result whose older instructions have not all been written stays in the buffer and does not reach the write port. Retirement stops at the first unfinished slot.
- R6: When the oldest slot has finished with an exception, `excValid` is high for one cycle and `excTag` carries that slot's tag. No write happens in that cycle, and no instruction dispatched after the faulting one is ever written.
- R7: If the oldest slot finishes cleanly and the next one has finished with an exception, only the oldest is written in that cycle. The exception is reported in the following cycle.
- R8: After an exception, results still in flight are discarded. The next accepted lane 0 takes the faulting slot's tag.
- R9: After reset the buffer is empty, `dispReady` is high, no write or exception is signalled, and the dispatch tags are 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dispValid | input | 2 | Per-lane dispatch request, bit 0 older |
| dispIsFp | input | 2 | Per-lane unit select, 1 means floating-point |
| dispExc | input | 2 | Per-lane flag that the stub reports an exception |
| dispDest | input | 10 | Destination register index per lane, lane 0 in bits 4:0 |
| dispData | input | 64 | Result value the stub returns per lane, lane 0 in bits 31:0 |
| dispReady | output | 1 | Both lanes may be accepted this cycle |
| dispTag | output | 6 | Slot tags offered to lane 0 (bits 2:0) and lane 1 (bits 5:3) |
| rfWe | output | 2 | Register-file write enables, bit 0 older |
| rfAddr | output | 10 | Write addresses, lane 0 in bits 4:0 |
| rfData | output | 64 | Write data, lane 0 in bits 31:0 |
| excValid | output | 1 | Oldest instruction is retiring with an exception |
| excTag | output | 3 | Slot tag of the faulting instruction |

## Verification
The sharpest overlap comes from pairing a floating-point instruction with a younger integer one that carries an exception. The integer result arrives two cycles early and waits. In the cycle the floating-point result arrives, one retirement must write while the exception is held back a cycle. The bench also provokes an exception at the oldest slot while younger integer and floating-point results are still inside the stubs. The reference model then judges that no late write escapes and that the next dispatch reuses the faulting tag. Dispatch stalling against a full buffer is exercised in the same runs, because retirement and allocation share the occupancy count every cycle.

// File: rtl/cb_pkg.sv
package cb_pkg;
  // Strobes from the control to the datapath, one cycle's worth.
  typedef struct packed {
    logic [1:0] allocEn; // lane allocates a slot at the tail
    logic [1:0] retEn;   // head (bit 0) and head+1 (bit 1) leave the buffer
    logic       flush;   // drop every slot and every in-flight result
  } cbStrobe_t;
endpackage

// File: rtl/cb_exec_stub.sv
module cb_exec_stub #(
  parameter int LAT = 1,
  parameter int DW  = 32,
  parameter int TW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          inVld,
  input  logic [TW-1:0] inTag,
  input  logic [DW-1:0] inData,
  input  logic          inExc,
  output logic          outVld,
  output logic [TW-1:0] outTag,
  output logic [DW-1:0] outData,
  output logic          outExc
);
  logic [LAT-1:0] sVld;
  logic [LAT-1:0] sExc;
  logic [TW-1:0]  sTag  [LAT];
  logic [DW-1:0]  sData [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      sVld <= '0;
    end else begin
      sVld[0] <= inVld;
      for (int s = 1; s < LAT; s++) sVld[s] <= sVld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    sTag[0]  <= inTag;
    sData[0] <= inData;
    sExc[0]  <= inExc;
    for (int s = 1; s < LAT; s++) begin
      sTag[s]  <= sTag[s-1];
      sData[s] <= sData[s-1];
      sExc[s]  <= sExc[s-1];
    end
  end

  assign outVld  = sVld[LAT-1];
  assign outTag  = sTag[LAT-1];
  assign outData = sData[LAT-1];
  assign outExc  = sExc[LAT-1];

  AST_KILL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !outVld); // R8
endmodule

// File: rtl/cb_ctrl.sv
module cb_ctrl import cb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    dispValid,
  input  logic [1:0]    dispIsFp,
  input  logic          h0Vld,
  input  logic          h0Done,
  input  logic          h0Exc,
  input  logic          h1Vld,
  input  logic          h1Done,
  input  logic          h1Exc,
  output cbStrobe_t     strobe,
  output logic [TW-1:0] headPtr,
  output logic [TW-1:0] tailPtr,
  output logic          dispReady,
  output logic          excValid,
  output logic [TW-1:0] excTag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] allocCnt;
  logic [CW-1:0] retCnt;
  logic          headFinished;
  logic          flushNow;
  logic          retire0;
  logic          retire1;
  logic [1:0]    allocEn;

  assign headFinished = h0Vld & h0Done;
  assign flushNow     = headFinished & h0Exc;
  assign retire0      = headFinished & ~h0Exc;
  assign retire1      = retire0 & h1Vld & h1Done & ~h1Exc;

  assign dispReady = (count <= CW'(DEPTH - 2)) & ~flushNow;
  assign allocEn   = dispValid & {2{dispReady}};
  assign allocCnt  = CW'(allocEn[0]) + CW'(allocEn[1]);
  assign retCnt    = CW'(retire0) + CW'(retire1);

  assign strobe.allocEn = allocEn;
  assign strobe.retEn   = {retire1, retire0};
  assign strobe.flush   = flushNow;

  assign excValid = flushNow;
  assign excTag   = headPtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (flushNow) begin
      tailPtr <= headPtr;
      count   <= '0;
    end else begin
      headPtr <= headPtr + TW'(retCnt);
      tailPtr <= tailPtr + TW'(allocCnt);
      count   <= count + allocCnt - retCnt;
    end
  end

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid[1] |-> dispValid[0]); // R1
  AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid == 2'b11) |-> (dispIsFp[0] != dispIsFp[1])); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flushNow |=> (count == '0 && tailPtr == headPtr && headPtr == $past(headPtr))); // R6
endmodule

// File: rtl/cb_datapath.sv
module cb_datapath import cb_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int DW      = 32,
  parameter int RW      = 5,
  parameter int INT_LAT = 1,
  parameter int FP_LAT  = 3,
  parameter int TW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cbStrobe_t       strobe,
  input  logic [TW-1:0]   headPtr,
  input  logic [TW-1:0]   tailPtr,
  input  logic [1:0]      dispIsFp,
  input  logic [1:0]      dispExc,
  input  logic [2*RW-1:0] dispDest,
  input  logic [2*DW-1:0] dispData,
  output logic            h0Vld,
  output logic            h0Done,
  output logic            h0Exc,
  output logic            h1Vld,
  output logic            h1Done,
  output logic            h1Exc,
  output logic [2*RW-1:0] rfAddr,
  output logic [2*DW-1:0] rfData
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] done;
  logic [DEPTH-1:0] exc;
  logic [RW-1:0]    dest [DEPTH];
  logic [DW-1:0]    res  [DEPTH];

  logic [TW-1:0] head1;
  logic [TW-1:0] tail1;
  assign head1 = headPtr + TW'(1);
  assign tail1 = tailPtr + TW'(1);

  logic [1:0]    cmpVld;
  logic [1:0]    cmpExc;
  logic [TW-1:0] cmpTag  [2];
  logic [DW-1:0] cmpData [2];

  // unit 0 is the integer stub, unit 1 the floating-point stub
  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam int LAT   = (u == 0) ? INT_LAT : FP_LAT;
    localparam bit IS_FP = (u == 1);
    logic pick0;
    logic pick1;
    assign pick0 = strobe.allocEn[0] & (dispIsFp[0] == IS_FP);
    assign pick1 = strobe.allocEn[1] & (dispIsFp[1] == IS_FP);

    cb_exec_stub #(.LAT(LAT), .DW(DW), .TW(TW)) u_stub (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (strobe.flush),
      .inVld  (pick0 | pick1),
      .inTag  (pick0 ? tailPtr : tail1),
      .inData (pick0 ? dispData[DW-1:0] : dispData[2*DW-1:DW]),
      .inExc  (pick0 ? dispExc[0] : dispExc[1]),
      .outVld (cmpVld[u]),
      .outTag (cmpTag[u]),
      .outData(cmpData[u]),
      .outExc (cmpExc[u])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.flush) begin
      vld  <= '0;
      done <= '0;
      exc  <= '0;
    end else begin
      if (strobe.retEn[0]) vld[headPtr] <= 1'b0;
      if (strobe.retEn[1]) vld[head1]   <= 1'b0;
      if (strobe.allocEn[0]) begin
        vld[tailPtr]  <= 1'b1;
        done[tailPtr] <= 1'b0;
        exc[tailPtr]  <= 1'b0;
      end
      if (strobe.allocEn[1]) begin
        vld[tail1]  <= 1'b1;
        done[tail1] <= 1'b0;
        exc[tail1]  <= 1'b0;
      end
      for (int u = 0; u < 2; u++) begin
        if (cmpVld[u]) begin
          done[cmpTag[u]] <= 1'b1;
          exc[cmpTag[u]]  <= cmpExc[u];
        end
      end
    end
  end

  // destination and temporary result storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.allocEn[0]) dest[tailPtr] <= dispDest[RW-1:0];
    if (strobe.allocEn[1]) dest[tail1]   <= dispDest[2*RW-1:RW];
    for (int u = 0; u < 2; u++) begin
      if (cmpVld[u]) res[cmpTag[u]] <= cmpData[u];
    end
  end

  assign h0Vld  = vld[headPtr];
  assign h0Done = done[headPtr];
  assign h0Exc  = exc[headPtr];
  assign h1Vld  = vld[head1];
  assign h1Done = done[head1];
  assign h1Exc  = exc[head1];

  assign rfAddr = {dest[head1], dest[headPtr]};
  assign rfData = {res[head1], res[headPtr]};

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.allocEn[0] |-> !vld[tailPtr]); // R1
  AST_INT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmpVld[0] |-> (vld[cmpTag[0]] && !done[cmpTag[0]])); // R3
  AST_FP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmpVld[1] |-> (vld[cmpTag[1]] && !done[cmpTag[1]])); // R3
  AST_RETIRE_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.retEn[1] |-> (vld[head1] && done[head1] && !exc[head1]
                         && strobe.retEn[0])); // R4
endmodule

// File: rtl/dual_commit_buf.sv
module dual_commit_buf import cb_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int DW      = 32,
  parameter int RW      = 5,
  parameter int INT_LAT = 1,
  parameter int FP_LAT  = 3,
  parameter int TW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      dispValid,
  input  logic [1:0]      dispIsFp,
  input  logic [1:0]      dispExc,
  input  logic [2*RW-1:0] dispDest,
  input  logic [2*DW-1:0] dispData,
  output logic            dispReady,
  output logic [2*TW-1:0] dispTag,
  output logic [1:0]      rfWe,
  output logic [2*RW-1:0] rfAddr,
  output logic [2*DW-1:0] rfData,
  output logic            excValid,
  output logic [TW-1:0]   excTag
);
  cbStrobe_t     strobe;
  logic [TW-1:0] headPtr;
  logic [TW-1:0] tailPtr;
  logic h0Vld, h0Done, h0Exc, h1Vld, h1Done, h1Exc;

  cb_ctrl #(.DEPTH(DEPTH), .TW(TW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dispValid(dispValid),
    .dispIsFp (dispIsFp),
    .h0Vld    (h0Vld),
    .h0Done   (h0Done),
    .h0Exc    (h0Exc),
    .h1Vld    (h1Vld),
    .h1Done   (h1Done),
    .h1Exc    (h1Exc),
    .strobe   (strobe),
    .headPtr  (headPtr),
    .tailPtr  (tailPtr),
    .dispReady(dispReady),
    .excValid (excValid),
    .excTag   (excTag)
  );

  cb_datapath #(.DEPTH(DEPTH), .DW(DW), .RW(RW), .INT_LAT(INT_LAT),
                .FP_LAT(FP_LAT), .TW(TW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .headPtr (headPtr),
    .tailPtr (tailPtr),
    .dispIsFp(dispIsFp),
    .dispExc (dispExc),
    .dispDest(dispDest),
    .dispData(dispData),
    .h0Vld   (h0Vld),
    .h0Done  (h0Done),
    .h0Exc   (h0Exc),
    .h1Vld   (h1Vld),
    .h1Done  (h1Done),
    .h1Exc   (h1Exc),
    .rfAddr  (rfAddr),
    .rfData  (rfData)
  );

  assign rfWe    = strobe.retEn;
  assign dispTag = {tailPtr + TW'(1), tailPtr};

  AST_NO_WRITE_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (rfWe == 2'b00)); // R6
  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> (!excValid && rfWe == 2'b00)); // R8
endmodule

// File: tb/dual_commit_buf_bench.sv
`timescale 1ns/1ps
module dual_commit_buf_bench;
  localparam int DEPTH = 8;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int TW = 3;
  localparam int INT_LAT = 1;
  localparam int FP_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]      dispValid = '0;
  logic [1:0]      dispIsFp = '0;
  logic [1:0]      dispExc = '0;
  logic [2*RW-1:0] dispDest = '0;
  logic [2*DW-1:0] dispData = '0;
  logic            dispReady;
  logic [2*TW-1:0] dispTag;
  logic [1:0]      rfWe;
  logic [2*RW-1:0] rfAddr;
  logic [2*DW-1:0] rfData;
  logic            excValid;
  logic [TW-1:0]   excTag;

  dual_commit_buf u_dual_commit_buf (
    .clk(clk), .rst_n(rst_n), .dispValid(dispValid), .dispIsFp(dispIsFp),
    .dispExc(dispExc), .dispDest(dispDest), .dispData(dispData),
    .dispReady(dispReady), .dispTag(dispTag), .rfWe(rfWe), .rfAddr(rfAddr),
    .rfData(rfData), .excValid(excValid), .excTag(excTag)
  );

  typedef struct { bit fp; bit exc; int dest; logic [31:0] data; } ins_t;
  typedef struct { int tag; bit exc; int dest; logic [31:0] data; int readyAt; } ent_t;

  ins_t sq[$];   // program stream waiting to dispatch
  ent_t mq[$];   // reference buffer, oldest first
  int checks = 0, errors = 0, cyc = 0, mTail = 0, nextId = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic add(input bit fp, input bit exc);
    ins_t it;
    it.fp = fp; it.exc = exc; it.dest = nextId % 32;
    it.data = 32'hA500_0000 ^ (32'(nextId) * 32'h0001_0F3B);
    nextId++;
    sq.push_back(it);
  endtask

  task automatic step();
    bit expExc, expReady;
    int nRet, n;
    expExc = 0; nRet = 0;
    if (mq.size() > 0 && mq[0].readyAt <= cyc) begin
      if (mq[0].exc) expExc = 1;
      else begin
        nRet = 1;
        if (mq.size() > 1 && mq[1].readyAt <= cyc && !mq[1].exc) nRet = 2;
      end
    end
    expReady = ((DEPTH - mq.size()) >= 2) && !expExc;
    check(dispReady == expReady, "R2", dispReady, expReady);
    check(dispTag[2:0] == 3'(mTail), "R1/R8", dispTag[2:0], mTail);
    check(dispTag[5:3] == 3'((mTail + 1) % DEPTH), "R1", dispTag[5:3], (mTail + 1) % DEPTH);
    check(rfWe[0] == (nRet >= 1), "R3/R4/R5", rfWe[0], nRet >= 1);
    check(rfWe[1] == (nRet == 2), "R4/R5/R7", rfWe[1], nRet == 2);
    for (int i = 0; i < nRet; i++) begin
      check(rfAddr[i*RW +: RW] == RW'(mq[i].dest), "R4 addr", rfAddr[i*RW +: RW], mq[i].dest);
      check(rfData[i*DW +: DW] == mq[i].data, "R4 data", rfData[i*DW +: DW], mq[i].data);
    end
    check(excValid == expExc, "R6/R7", excValid, expExc);
    if (expExc) check(excTag == 3'(mq[0].tag), "R6 tag", excTag, mq[0].tag);

    n = 0;
    if (sq.size() > 0) n = 1;
    if (sq.size() > 1 && sq[1].fp != sq[0].fp) n = 2;

    if (expExc) begin
      mTail = mq[0].tag;
      mq.delete();
    end else begin
      for (int i = 0; i < nRet; i++) void'(mq.pop_front());
    end

    dispValid = '0; dispIsFp = '0; dispExc = '0; dispDest = '0; dispData = '0;
    for (int i = 0; i < n; i++) begin
      dispValid[i] = 1'b1;
      dispIsFp[i] = sq[i].fp;
      dispExc[i] = sq[i].exc;
      dispDest[i*RW +: RW] = RW'(sq[i].dest);
      dispData[i*DW +: DW] = sq[i].data;
    end
    if (expReady) begin
      for (int i = 0; i < n; i++) begin
        ent_t e;
        e.tag = (mTail + i) % DEPTH; e.exc = sq[i].exc; e.dest = sq[i].dest;
        e.data = sq[i].data;
        e.readyAt = cyc + 1 + (sq[i].fp ? FP_LAT : INT_LAT);
        mq.push_back(e);
      end
      for (int i = 0; i < n; i++) void'(sq.pop_front());
      mTail = (mTail + n) % DEPTH;
    end
    cyc++;
  endtask

  task automatic run();
    int guard = 0;
    while ((sq.size() > 0 || mq.size() > 0) && guard < 2000) begin
      @(negedge clk); step(); guard++;
    end
    for (int i = 0; i < 3; i++) begin @(negedge clk); step(); end
  endtask

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_sim();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R9: state right after reset
    check(dispReady == 1'b1, "R9", dispReady, 1);
    check(rfWe == 2'b00, "R9", rfWe, 0);
    check(excValid == 1'b0, "R9", excValid, 0);
    check(dispTag == 6'b001_000, "R9", dispTag, 6'b001_000);
    step();

    // R3: single latencies, integer then floating-point
    add(0, 0); run();
    add(1, 0); run();
    // R5: floating-point older, integer younger finishes first; fills buffer (R2)
    for (int i = 0; i < 12; i++) begin add(1, 0); add(0, 0); end
    run();
    // integer older in lane 0
    for (int i = 0; i < 8; i++) begin add(0, 0); add(1, 0); end
    run();
    // single-unit streams
    for (int i = 0; i < 6; i++) add(1, 0);
    for (int i = 0; i < 6; i++) add(0, 0);
    run();
    // R6/R8: faulting oldest with younger work in flight, then new program
    add(1, 1); add(0, 0); add(0, 0); add(1, 0); add(0, 0);
    run();
    add(0, 0); add(1, 0); run();
    // R7: clean oldest and faulting next one finish in the same cycle
    add(1, 0); add(0, 1); add(1, 0); add(0, 0);
    run();
    // integer fault directly behind a pending floating-point op
    add(1, 0); add(0, 0); add(0, 1); add(0, 0); run();
    // mixed pseudo-random stream
    for (int i = 0; i < 60; i++) add(1'($urandom % 2), ($urandom % 12) == 0);
    run();
    finish_sim();
  end
endmodule